// File: doc/BRIEF.md
# Multi-Port Four-Phase Selection Collector

The collector sits in the packet engine's clock domain and gathers work selections from a set of selector ports. Each port lives in its own processing-unit clock, unrelated to the engine clock. A port presents a unit identifier and an operation code, then raises a request line. The collector brings each request line into its own clock through a two-stage synchronizer. It picks one waiting port at a time in rotating order and captures that port's identifier and operation code.

The captured identifier is turned into the base address of the unit's private dual-port memory window. Every unit owns a window of 2048 32-bit words, so the base is the identifier placed above eleven zero bits. The address and the operation code are handed to the packet engine. When the engine reports completion, the collector raises that port's acknowledge. The acknowledge stays high until the synchronized request is seen low, and only then drops. This completes the handshake: request up, acknowledge up, request down, acknowledge down.

Top module: `sel_collector`

## Requirements
- R1: After reset every acknowledge output is low and the engine valid output is low.
- R2: While the engine valid output is high, the engine base address equals the served port's identifier shifted left by 11, zero-extended to the address width (19 bits by default, with 8-bit identifiers).
- R3: While the engine valid output is high, the engine operation output equals the operation code the served port presented with its request.
- R4: Once the engine valid output is high, it stays high with an unchanged address and operation until a cycle in which the engine done input is high. In the cycle after that, valid is low.
- R5: A served port's acknowledge stays low until the engine done input is sampled high, and it rises on the next clock edge. No other port's acknowledge changes because of that completion.
- R6: A raised acknowledge stays high for as long as its request stays high. After the request falls, the acknowledge falls on the third engine clock edge: two synchronizer stages plus the acknowledge register.
- R7: A port whose acknowledge is high is not served again, even if its request stays high. After its acknowledge has fallen, a new request from that port is served normally.
- R8: Ports with a synchronized request pending are served in rotating order. The port chosen is the first pending one at or after the index following the last served port, wrapping from the highest index to 0. After reset the search starts at index 0.
- R9: An engine done pulse while the engine valid output is low has no effect: acknowledges and engine valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| port_req_i | input | NUM_PORTS | Request line of each port, asynchronous to clk |
| port_id_i | input | NUM_PORTS*ID_W | Unit identifier of each port, port p in bits [p*ID_W +: ID_W] |
| port_op_i | input | NUM_PORTS*OP_W | Operation code of each port, port p in bits [p*OP_W +: OP_W] |
| port_ack_o | output | NUM_PORTS | Registered acknowledge to each port |
| eng_valid_o | output | 1 | A selection is being presented to the engine |
| eng_base_o | output | ADDR_W | Memory base address of the selected unit |
| eng_op_o | output | OP_W | Operation code of the selected unit |
| eng_done_i | input | 1 | Engine finished the presented operation |

## Verification
Random batches raise requests on random subsets of ports in the same cycle, with random identifiers and operation codes. Serving order then shows whether the rotating pointer advances from the last served port, and not from a fixed index or from the lowest pending one. Engine completion delays are varied, so an acknowledge that rises before completion, or an address that moves while waiting, shows up. Directed cases hold a request high after its acknowledge to separate correct acknowledge release from early release or re-service. A completion pulse with no operation in flight is also applied.

// File: rtl/sc_pkg.sv
package sc_pkg;
    // Collector phase: waiting for a port, or presenting a selection to the engine
    typedef enum logic {
        PH_WAIT  = 1'b0,
        PH_ISSUE = 1'b1
    } coll_phase_e;
endpackage

// File: rtl/sc_sync_bank.sv
module sc_sync_bank #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain_d, chain_q;
            always_comb begin
                chain_d = {chain_q[STAGES-2:0], async_i[g]};
            end
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end
            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sc_rr_pick.sv
module sc_rr_pick #(
    parameter int N  = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pending_i,
    input  logic [PW-1:0] start_i,
    output logic          found_o,
    output logic [PW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // scan from farthest to nearest so the nearest pending port wins
        for (int k = N - 1; k >= 0; k--) begin
            int cand;
            cand = int'(start_i) + k;
            if (cand >= N) cand = cand - N;
            if (pending_i[cand]) begin
                found_o = 1'b1;
                idx_o   = PW'(cand);
            end
        end
    end
endmodule

// File: rtl/sc_base_map.sv
module sc_base_map #(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 19,
    parameter int SHIFT  = 11
) (
    input  logic [ID_W-1:0]   id_i,
    output logic [ADDR_W-1:0] base_o
);
    localparam int USED = ID_W + SHIFT;
    generate
        if (USED <= ADDR_W) begin : g_fit
            assign base_o = ADDR_W'({id_i, {SHIFT{1'b0}}});
        end else begin : g_trunc
            logic [USED-1:0] wide;
            assign wide   = {id_i, {SHIFT{1'b0}}};
            assign base_o = wide[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/sel_collector.sv
module sel_collector #(
    parameter int NUM_PORTS = 4,
    parameter int ID_W      = 8,
    parameter int OP_W      = 2,
    parameter int ADDR_W    = 19,
    parameter int WIN_SHIFT = 11,
    parameter int SYNC_LEN  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PORTS-1:0]      port_req_i,
    input  logic [NUM_PORTS*ID_W-1:0] port_id_i,
    input  logic [NUM_PORTS*OP_W-1:0] port_op_i,
    output logic [NUM_PORTS-1:0]      port_ack_o,
    output logic                      eng_valid_o,
    output logic [ADDR_W-1:0]         eng_base_o,
    output logic [OP_W-1:0]           eng_op_o,
    input  logic                      eng_done_i
);
    import sc_pkg::*;

    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(NUM_PORTS - 1);

    typedef struct packed {
        coll_phase_e          phase;
        logic [PW-1:0]        cur;
        logic [PW-1:0]        ptr;
        logic [ID_W-1:0]      id;
        logic [OP_W-1:0]      op;
        logic [NUM_PORTS-1:0] ack;
    } coll_st_t;

    coll_st_t st_d, st_q;

    logic [NUM_PORTS-1:0] req_s;
    logic [NUM_PORTS-1:0] pending;
    logic                 pick_found;
    logic [PW-1:0]        pick_idx;

    sc_sync_bank #(.WIDTH(NUM_PORTS), .STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(port_req_i),
        .sync_o (req_s)
    );

    // a port may be chosen only while its acknowledge is low
    assign pending = req_s & ~st_q.ack;

    sc_rr_pick #(.N(NUM_PORTS)) u_pick (
        .pending_i(pending),
        .start_i  (st_q.ptr),
        .found_o  (pick_found),
        .idx_o    (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        // release acknowledges whose request has been seen low
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (st_q.ack[p] && !req_s[p]) st_d.ack[p] = 1'b0;
        end
        case (st_q.phase)
            PH_WAIT: begin
                if (pick_found) begin
                    st_d.phase = PH_ISSUE;
                    st_d.cur   = pick_idx;
                    st_d.id    = port_id_i[pick_idx*ID_W +: ID_W];
                    st_d.op    = port_op_i[pick_idx*OP_W +: OP_W];
                end
            end
            PH_ISSUE: begin
                if (eng_done_i) begin
                    st_d.phase        = PH_WAIT;
                    st_d.ack[st_q.cur] = 1'b1;
                    st_d.ptr          = (st_q.cur == LAST_IDX) ? '0 : st_q.cur + 1'b1;
                end
            end
            default: st_d.phase = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_WAIT;
            st_q.cur   <= '0;
            st_q.ptr   <= '0;
            st_q.id    <= '0;
            st_q.op    <= '0;
            st_q.ack   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sc_base_map #(.ID_W(ID_W), .ADDR_W(ADDR_W), .SHIFT(WIN_SHIFT)) u_map (
        .id_i  (st_q.id),
        .base_o(eng_base_o)
    );

    assign eng_valid_o = (st_q.phase == PH_ISSUE);
    assign eng_op_o    = st_q.op;
    assign port_ack_o  = st_q.ack;

    // R4
    hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid_o && !eng_done_i) |=> (eng_valid_o && $stable(eng_base_o) && $stable(eng_op_o)));

    // R4
    drop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid_o && eng_done_i) |=> !eng_valid_o);

    // R9
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_valid_o && !pick_found) |=> (!eng_valid_o && ((port_ack_o & ~$past(port_ack_o)) == '0)));

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_chk
            // R5
            ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(port_ack_o[gp]) |-> ($past(eng_done_i) && $past(eng_valid_o)));
            // R6
            ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (port_ack_o[gp] && req_s[gp]) |=> port_ack_o[gp]);
            // R7
            no_reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (port_ack_o[gp] && eng_valid_o) |-> (st_q.cur != PW'(gp)) || $past(eng_valid_o));
        end
    endgenerate
endmodule

// File: tb/tb_sel_collector.sv
`timescale 1ns/1ps
module tb_sel_collector;
    localparam int N      = 4;
    localparam int ID_W   = 8;
    localparam int OP_W   = 2;
    localparam int ADDR_W = 19;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         req = '0;
    logic [N*ID_W-1:0]    ids = '0;
    logic [N*OP_W-1:0]    ops = '0;
    logic [N-1:0]         ack;
    logic                 valid;
    logic [ADDR_W-1:0]    base;
    logic [OP_W-1:0]      op;
    logic                 done = 1'b0;

    int checks = 0;
    int fails  = 0;
    int ptr_m  = 0;

    always #2.5 clk = ~clk;

    sel_collector #(.NUM_PORTS(N), .ID_W(ID_W), .OP_W(OP_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .port_req_i(req), .port_id_i(ids), .port_op_i(ops),
        .port_ack_o(ack), .eng_valid_o(valid), .eng_base_o(base), .eng_op_o(op),
        .eng_done_i(done)
    );

    function automatic logic [ADDR_W-1:0] exp_base(input logic [ID_W-1:0] id);
        return ADDR_W'({id, 11'b0});
    endfunction

    function automatic int exp_next(input logic [N-1:0] pend, input int start);
        for (int k = 0; k < N; k++) begin
            if (pend[(start + k) % N]) return (start + k) % N;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_valid();
        int guard = 0;
        while (!valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // serve one selection expected from port p; drop request when acked unless hold
    task automatic serve(input int p, input int delay, input bit hold);
        logic [ADDR_W-1:0] b0;
        logic [OP_W-1:0]   o0;
        wait_valid();
        chk(valid, "R8 valid", valid, 1);
        chk(base == exp_base(ids[p*ID_W +: ID_W]), "R2 base", base, exp_base(ids[p*ID_W +: ID_W]));
        chk(op == ops[p*OP_W +: OP_W], "R3 op", op, ops[p*OP_W +: OP_W]);
        b0 = base; o0 = op;
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk(ack[p] == 1'b0, "R5 ack early", ack[p], 0);
            chk(valid && base == b0 && op == o0, "R4 stable", base, b0);
        end
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk(ack[p] == 1'b1, "R5 ack rise", ack[p], 1);
        chk(valid == 1'b0 || req != '0, "R4 drop", valid, 0);
        ptr_m = (p + 1) % N;
        if (!hold) begin
            req[p] = 1'b0;
            tick(2);
            chk(ack[p] == 1'b1, "R6 ack held through sync", ack[p], 1);
            tick(1);
            chk(ack[p] == 1'b0, "R6 ack fall", ack[p], 0);
        end
    endtask

    task automatic run_all();
        // R1 reset state
        tick(3);
        chk(ack == '0, "R1 ack", ack, 0);
        chk(valid == 1'b0, "R1 valid", valid, 0);
        rst_n = 1'b1;
        tick(2);

        // R9: done with nothing in flight
        done = 1'b1; tick(1); done = 1'b0; tick(2);
        chk(ack == '0 && !valid, "R9 idle done", {ack, valid}, 0);

        // directed: all four at once, rotation from 0
        for (int p = 0; p < N; p++) begin
            ids[p*ID_W +: ID_W] = ID_W'(8'hF0 + p);
            ops[p*OP_W +: OP_W] = OP_W'(p);
        end
        ids[3*ID_W +: ID_W] = 8'hFF;
        req = '1;
        for (int s = 0; s < N; s++) serve(s, s, 1'b0);

        // R7: hold request high after ack
        ids[2*ID_W +: ID_W] = 8'h5A;
        ops[2*OP_W +: OP_W] = 2'd3;
        req[2] = 1'b1;
        serve(2, 1, 1'b1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!valid, "R7 no reserve", valid, 0);
            chk(ack[2], "R6 ack held", ack[2], 1);
        end
        // R9 while a port sits acked
        done = 1'b1; tick(1); done = 1'b0; tick(1);
        chk(!valid && ack == 4'b0100, "R9 done ignored", ack, 4'b0100);
        req[2] = 1'b0;
        tick(3);
        chk(ack[2] == 1'b0, "R6 release", ack[2], 0);
        ids[2*ID_W +: ID_W] = 8'h11;
        req[2] = 1'b1;
        serve(2, 0, 1'b0);
        chk(1'b1, "R7 reserved after fall", 0, 0);

        // random batches
        for (int b = 0; b < 40; b++) begin
            logic [N-1:0] pend;
            pend = N'($urandom_range(1, (1 << N) - 1));
            for (int p = 0; p < N; p++) begin
                ids[p*ID_W +: ID_W] = ID_W'($urandom);
                ops[p*OP_W +: OP_W] = OP_W'($urandom);
            end
            req = pend;
            while (pend != '0) begin
                int e;
                e = exp_next(pend, ptr_m);
                serve(e, $urandom_range(0, 4), 1'b0);
                pend[e] = 1'b0;
            end
            tick(4);
            chk(ack == '0 && !valid, "R8 batch idle", ack, 0);
        end
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        void'($urandom(32'd20240611));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule